// File: doc/BRIEF.md
# Non-Restoring Array Divider

This block divides an unsigned double-width dividend by an unsigned single-width divisor in one combinational pass. With the default sizing it takes an 8-bit dividend and a 4-bit divisor and produces a 4-bit quotient and a 4-bit remainder. There is no clock inside the block. The outputs follow the inputs after the array has settled, so a surrounding pipeline stage can register them.

The datapath is a grid of identical cells. Each cell is a full adder whose divisor input passes through an XOR gate, so one control line makes a whole row either add or subtract the divisor. The first row always subtracts. Every later row subtracts when the row above ended non-negative, and adds back when it ended negative, so no row ever restores a partial remainder. Each row's sign yields one quotient bit, from the most significant bit down. The dividend enters the grid pre-shifted by one place, so its top bit never feeds a cell. That bit is folded into the sign of the first row by a single gate.

A final add-only row corrects a negative last partial remainder. A small comparator beside the grid raises an overflow flag when the quotient would not fit in the output width. When that flag is high, the quotient and the remainder carry no meaning.

Top module: `nr_array_divider`

## Requirements
- R1: When `overflow_o` is low, `quotient_o` equals the integer part of `dividend_i / divisor_i`.
- R2: When `overflow_o` is low, `remainder_o` equals `dividend_i mod divisor_i` and is strictly less than `divisor_i`, including cases where the last array row ends negative.
- R3: `overflow_o` is high exactly when the upper half of the dividend (bits 7..4) is greater than or equal to `divisor_i`.
- R4: A zero divisor always raises `overflow_o`, whatever the dividend.
- R5: Dividend 123 (0111_1011) over divisor 12 (1100) yields quotient 10 (1010), remainder 3 (0011) and no overflow.
- R6: A dividend with bit 7 set and the largest non-overflowing upper half, 239 over 15, yields quotient 15, remainder 14 and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend_i | input | 8 | Unsigned dividend |
| divisor_i | input | 4 | Unsigned divisor |
| quotient_o | output | 4 | Unsigned quotient, meaningful only when overflow_o is low |
| remainder_o | output | 4 | Unsigned remainder, meaningful only when overflow_o is low |
| overflow_o | output | 1 | High when the quotient cannot fit in 4 bits or the divisor is zero |

## Verification
The overflow comparator and the cell array evaluate the same operands together. For every operand pair, the bench must therefore judge both the flag and the arithmetic at the same instant. The exhaustive sweep runs every divisor against upper halves on both sides of the boundary. The pairs where the upper half equals the divisor must raise the flag. The pairs one below it must leave the flag low, and there the quotient must come out all ones and the remainder must be correct. The remainder correction row and the quotient bits settle in the same pass. Dividends whose last row ends negative, such as 123 over 12, show whether the corrected remainder and the unaffected quotient agree with plain division.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef struct packed {
    logic sum;
    logic cout;
  } cas_bit_t;
endpackage

// File: rtl/nrdiv_cas_cell.sv
module nrdiv_cas_cell
  import nrdiv_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     sub_i,
  input  logic     cin_i,
  output cas_bit_t out_o
);
  logic b_eff;
  logic half;

  // XOR turns the divisor bit into its complement when the row subtracts
  assign b_eff      = b_i ^ sub_i;
  assign half       = a_i ^ b_eff;
  assign out_o.sum  = half ^ cin_i;
  assign out_o.cout = (a_i & b_eff) | (cin_i & half);
endmodule

// File: rtl/nrdiv_cas_row.sv
module nrdiv_cas_row
  import nrdiv_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] carry;
  cas_bit_t   res [W];

  // carry-in of one completes the two's complement on subtract
  assign carry[0] = sub_i;

  for (genvar j = 0; j < W; j++) begin : g_cell
    nrdiv_cas_cell u_cell (
      .a_i  (a_i[j]),
      .b_i  (b_i[j]),
      .sub_i(sub_i),
      .cin_i(carry[j]),
      .out_o(res[j])
    );
    assign sum_o[j]     = res[j].sum;
    assign carry[j + 1] = res[j].cout;
  end

  logic unused_carry_top;
  assign unused_carry_top = carry[W];
endmodule

// File: rtl/nrdiv_ovf_detect.sv
module nrdiv_ovf_detect #(
  parameter int QW = 4
) (
  input  logic [QW-1:0] upper_i,
  input  logic [QW-1:0] divisor_i,
  output logic          ovf_o
);
  // quotient fits only if the upper half is below the divisor
  assign ovf_o = (upper_i >= divisor_i);
endmodule

// File: rtl/nr_array_divider.sv
module nr_array_divider #(
  parameter int QW = 4
) (
  input  logic [2*QW-1:0] dividend_i,
  input  logic [QW-1:0]   divisor_i,
  output logic [QW-1:0]   quotient_o,
  output logic [QW-1:0]   remainder_o,
  output logic            overflow_o
);
  localparam int DW = 2 * QW;
  localparam int RW = QW + 1;

  logic [RW-1:0] dvs_ext;
  logic [RW-1:0] prem [1:QW];

  assign dvs_ext = {1'b0, divisor_i};

  for (genvar i = 0; i < QW; i++) begin : g_row
    logic [RW-1:0] row_in;
    logic [RW-1:0] row_sum;
    logic          row_sub;

    if (i == 0) begin : g_first
      // preshifted dividend: the top bit stays out of the cells and is
      // folded into the sign afterwards (adds 2^QW modulo 2^RW)
      assign row_in      = {1'b0, dividend_i[DW-2:QW-1]};
      assign row_sub     = 1'b1;
      assign prem[i + 1] = {row_sum[QW] ^ dividend_i[DW-1], row_sum[QW-1:0]};
    end else begin : g_next
      assign row_in      = {prem[i][QW-1:0], dividend_i[QW-1-i]};
      assign row_sub     = ~prem[i][QW];
      assign prem[i + 1] = row_sum;
    end

    nrdiv_cas_row #(.W(RW)) u_row (
      .a_i  (row_in),
      .b_i  (dvs_ext),
      .sub_i(row_sub),
      .sum_o(row_sum)
    );

    assign quotient_o[QW-1-i] = ~prem[i + 1][QW];
  end

  // correction row: add the divisor back once when the last row is negative
  logic [RW-1:0] fix_add;
  logic [RW-1:0] fix_sum;

  assign fix_add = dvs_ext & {RW{prem[QW][QW]}};

  nrdiv_cas_row #(.W(RW)) u_fix (
    .a_i  (prem[QW]),
    .b_i  (fix_add),
    .sub_i(1'b0),
    .sum_o(fix_sum)
  );

  assign remainder_o = fix_sum[QW-1:0];

  logic unused_fix_msb;
  assign unused_fix_msb = fix_sum[QW];

  nrdiv_ovf_detect #(.QW(QW)) u_ovf (
    .upper_i  (dividend_i[DW-1:QW]),
    .divisor_i(divisor_i),
    .ovf_o    (overflow_o)
  );
endmodule

// File: rtl/nr_array_divider_chk.sv
module nr_array_divider_chk #(
  parameter int QW = 4
) (
  input logic [2*QW-1:0] dividend_i,
  input logic [QW-1:0]   divisor_i,
  input logic [QW-1:0]   quotient_o,
  input logic [QW-1:0]   remainder_o,
  input logic            overflow_o
);
  localparam int DW = 2 * QW;

  logic [DW-1:0] recombined;
  logic [DW-1:0] limit;

  assign recombined = DW'(quotient_o) * DW'(divisor_i) + DW'(remainder_o);
  assign limit      = {divisor_i, {QW{1'b0}}};

  always_comb begin
    if (!overflow_o) begin
      assert_recombine_R1: assert (recombined == dividend_i)
        else $error("R1 quotient*divisor+remainder mismatch");
      assert_rem_range_R2: assert (remainder_o < divisor_i)
        else $error("R2 remainder not below divisor");
    end
    assert_ovf_bound_R3: assert (overflow_o == (dividend_i >= limit))
      else $error("R3 overflow flag disagrees with full-width bound");
    if (divisor_i == '0) begin
      assert_zero_div_R4: assert (overflow_o)
        else $error("R4 zero divisor without overflow");
    end
  end
endmodule

bind nr_array_divider nr_array_divider_chk #(.QW(QW)) u_chk (
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o),
  .overflow_o (overflow_o)
);

// File: tb/nr_array_divider_test.sv
module nr_array_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dividend = '0;
  logic [3:0] divisor = '0;
  logic [3:0] quotient;
  logic [3:0] remainder;
  logic       overflow;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [7:0] a;
    logic [3:0] d;
    logic [3:0] q;
    logic [3:0] r;
    logic       ovf;
    string      tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  nr_array_divider uut (
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .quotient_o (quotient),
    .remainder_o(remainder),
    .overflow_o (overflow)
  );

  task automatic drive(input logic [7:0] a, input logic [3:0] d, input string tag);
    exp_t e;
    @(posedge clk);
    dividend = a;
    divisor  = d;
    e.a   = a;
    e.d   = d;
    e.tag = tag;
    e.ovf = (a[7:4] >= d);
    if (!e.ovf) begin
      e.q = 4'(a / d);
      e.r = 4'(a % d);
    end else begin
      e.q = '0;
      e.r = '0;
    end
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      cur = sb.pop_front();
      total++;
      if (overflow !== cur.ovf) begin
        bad++;
        $display("FAIL %s %s overflow a=%0d d=%0d actual=%b expected=%b",
                 (cur.d == 0) ? "R4" : "R3", cur.tag, cur.a, cur.d, overflow, cur.ovf);
      end
      if (!cur.ovf) begin
        total++;
        if (quotient !== cur.q) begin
          bad++;
          $display("FAIL R1 %s quotient a=%0d d=%0d actual=%0d expected=%0d",
                   cur.tag, cur.a, cur.d, quotient, cur.q);
        end
        total++;
        if (remainder !== cur.r) begin
          bad++;
          $display("FAIL R2 %s remainder a=%0d d=%0d actual=%0d expected=%0d",
                   cur.tag, cur.a, cur.d, remainder, cur.r);
        end
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // reset-state inputs are zero: zero divisor must flag overflow (R4)
    @(negedge clk);
    total++;
    if (overflow !== 1'b1) begin
      bad++;
      $display("FAIL R4 idle zero inputs actual=%b expected=1", overflow);
    end
    drive(8'd123, 4'd12, "R5");
    drive(8'd239, 4'd15, "R6");
    drive(8'd255, 4'd0,  "R4");
    drive(8'd224, 4'd14, "R3 boundary");
    drive(8'd223, 4'd14, "R3 boundary");
    for (int a = 0; a < 256; a++) begin
      for (int d = 0; d < 16; d++) begin
        drive(a[7:0], d[3:0], "sweep");
      end
    end
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finish before 20000 cycles");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule